// File: doc/BRIEF.md
# Chained Audio DMA Engine

A single-channel DMA engine that streams audio between memory and a peripheral in fixed 64-byte bursts (16 words of 32 bits). It keeps an active descriptor (address and byte count) and one queued descriptor behind it. When the active count runs out, the queued one takes over on the very next cycle, so a stream has no idle gap between buffers. Software reaches the engine through a small 32-bit register port. The memory side issues one burst request at a time with a request/grant handshake and a completion strobe that may carry an error. One interrupt line reports terminal count and errors.

The sequencing is a four-state machine. `ST_IDLE` moves to `ST_REQ` when the engine is enabled, a descriptor is loaded and the reset bit is clear. `ST_REQ` goes to `ST_WAIT` on grant, or back to `ST_IDLE` if the engine is disabled or reset before a grant arrives. `ST_WAIT` handles the completion strobe. It goes to `ST_DRAIN` if reset was requested during a capture burst. It goes to `ST_IDLE` on reset, on an error, on halt, or at terminal count with nothing queued. Otherwise it goes straight back to `ST_REQ`, and that includes a promotion of the queued descriptor. `ST_DRAIN` counts down `DRAIN_CYCLES` cycles and then returns to `ST_IDLE`.

Top module: `chain_dma`

## Requirements
- R1: After reset the control word reads zero, `mem_req` is low and `irq` is low.
- R2: Port selects: 0 = control/status, 1 = address (write queues, read gives the active address), 2 = count (write stages, read gives the active count). Control bits: 0 INT_PEND, 1 ERR_PEND, 2 TC, 3 INT_EN, 4 DMA_EN, 5 CNT_EN, 6 NEXT_EN, 7 DIR, 8 RESET, 9 CYC_PEND (read only), 10 DRAIN (read only), 11 ARMED (read only).
- R3: Software writes the count before the address, and the address write commits the pair. If no descriptor is active, the pair becomes the active one. Otherwise it becomes the queued one and ARMED reads 1. A pair with a zero count is ignored. The low 6 bits of both count and address are dropped.
- R4: The engine issues one burst per 64 bytes, at addresses that step by 64 from the start address. `mem_we` equals DIR, where 1 means capture (the device writes into memory).
- R5: When the active count reaches zero, TC is set, and INT_PEND is set only if INT_EN is on.
- R6: At terminal count with NEXT_EN and ARMED both set, the queued descriptor becomes active. The next request is raised on the cycle after the completion, and ARMED clears. Without a queued descriptor, the engine stops and DMA_EN reads 0.
- R7: A completion with `mem_err` sets ERR_PEND, clears DMA_EN, and no further request follows.
- R8: Writing RESET=1 does the following. It clears ERR_PEND and INT_PEND. It drops DMA_EN and both descriptors. It withdraws any ungranted request. RESET cannot return to 0 while CYC_PEND or DRAIN reads 1. If a capture burst was in flight, DRAIN reads 1 for `DRAIN_CYCLES` cycles after that burst completes.
- R9: Clearing DMA_EN stops the engine once the in-flight burst completes. While the engine is enabled, a request is held until it is granted.
- R10: INT_PEND, ERR_PEND and TC are write-one-to-clear. Writing 0 to them leaves them unchanged, and writing back a value just read clears the ones that were set.
- R11: With CNT_EN clear the count does not decrement and TC never sets.
- R12: `irq` is (INT_PEND and INT_EN) or ERR_PEND, and it stays high until those bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Burst request |
| mem_gnt | input | 1 | Burst grant |
| mem_we | output | 1 | Burst direction, 1 = write to memory |
| mem_addr | output | ADDR_W | Burst start address |
| mem_done | input | 1 | Burst completion strobe |
| mem_err | input | 1 | Error flag with completion |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps burst count, direction and memory latency, and checks every burst address, every direction flag and the spacing between grants. A design that decremented wrongly would emit the wrong number of bursts. A design that left a gap at promotion would show a wider spacing at the descriptor boundary. An error injected mid-stream must stop the engine exactly after the failing burst. A design that kept running would log extra bursts. A reset issued during a long capture burst must keep RESET stuck high and then hold DRAIN for exactly four cycles. A design that released early, or skipped the drain, would show the wrong reset bit or the wrong drain length. The bench also tries zero counts, unaligned values, a disabled count and writes of 0 to the status bits, looking for any state they wrongly disturb.

// File: rtl/chain_dma_pkg.sv
`timescale 1ns/1ps
package chain_dma_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DRAIN} dma_state_t;

    localparam int B_INT  = 0;
    localparam int B_ERR  = 1;
    localparam int B_TC   = 2;
    localparam int B_INTEN = 3;
    localparam int B_EN   = 4;
    localparam int B_CNTEN = 5;
    localparam int B_NXTEN = 6;
    localparam int B_DIR  = 7;
    localparam int B_RST  = 8;
    localparam int B_CYC  = 9;
    localparam int B_DRN  = 10;
    localparam int B_ARM  = 11;

    localparam logic [1:0] SEL_CSR  = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
endpackage

// File: rtl/cdma_fsm.sv
`timescale 1ns/1ps
module cdma_fsm
    import chain_dma_pkg::*;
#(
    parameter int DRAIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic dma_en,
    input  logic rst_bit,
    input  logic dir_wr,
    input  logic last,
    input  logic can_chain,
    input  logic mem_gnt,
    input  logic mem_done,
    input  logic mem_err,
    output logic mem_req,
    output logic cyc_pend,
    output logic draining,
    output logic step,
    output logic err_evt,
    output logic tc_evt,
    output logic promote,
    output logic stop
);
    localparam int DW = $clog2(DRAIN_CYCLES) + 1;

    dma_state_t     state, state_nx;
    logic [DW-1:0]  drn_cnt;

    // state register and drain counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            drn_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_DRAIN && state != ST_DRAIN)
                drn_cnt <= DW'(DRAIN_CYCLES - 1);
            else if (state == ST_DRAIN && drn_cnt != '0)
                drn_cnt <= drn_cnt - 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (run) state_nx = ST_REQ;
            ST_REQ: begin
                if (mem_gnt)                 state_nx = ST_WAIT;
                else if (!dma_en || rst_bit) state_nx = ST_IDLE;
            end
            ST_WAIT: begin
                if (mem_done) begin
                    if (rst_bit)      state_nx = dir_wr ? ST_DRAIN : ST_IDLE;
                    else if (mem_err) state_nx = ST_IDLE;
                    else if (dma_en && (!last || can_chain)) state_nx = ST_REQ;
                    else              state_nx = ST_IDLE;
                end
            end
            ST_DRAIN: if (drn_cnt == '0) state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req  = (state == ST_REQ);
        cyc_pend = (state == ST_WAIT);
        draining = (state == ST_DRAIN);
        step     = cyc_pend && mem_done && !mem_err && !rst_bit;
        err_evt  = cyc_pend && mem_done && mem_err && !rst_bit;
        tc_evt   = step && last;
        promote  = tc_evt && can_chain;
        stop     = tc_evt && !can_chain;
    end
endmodule

// File: rtl/cdma_desc.sv
`timescale 1ns/1ps
module cdma_desc #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int BURST_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              cnt_en,
    input  logic              step,
    input  logic              promote,
    input  logic              stop,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              cur_valid,
    output logic              armed,
    output logic              last
);
    localparam int OFF_W = $clog2(BURST_BYTES);
    localparam logic [CNT_W-1:0]  CNT_MASK  = ~CNT_W'((1 << OFF_W) - 1);
    localparam logic [ADDR_W-1:0] ADDR_MASK = ~ADDR_W'((1 << OFF_W) - 1);

    logic [ADDR_W-1:0] nxt_addr;
    logic [CNT_W-1:0]  nxt_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_cnt   <= '0;
            nxt_addr  <= '0;
            nxt_cnt   <= '0;
            cur_valid <= 1'b0;
            armed     <= 1'b0;
        end else begin
            if (cnt_wr) nxt_cnt <= cnt_wdata & CNT_MASK;
            if (flush) begin
                cur_valid <= 1'b0;
                armed     <= 1'b0;
            end else begin
                if (step) begin
                    cur_addr <= cur_addr + ADDR_W'(BURST_BYTES);
                    if (cnt_en) cur_cnt <= cur_cnt - CNT_W'(BURST_BYTES);
                end
                if (promote) begin
                    cur_addr <= nxt_addr;
                    cur_cnt  <= nxt_cnt;
                    armed    <= 1'b0;
                end
                if (stop) cur_valid <= 1'b0;
                if (addr_wr && nxt_cnt != '0) begin
                    if (!cur_valid) begin
                        cur_addr  <= addr_wdata & ADDR_MASK;
                        cur_cnt   <= nxt_cnt;
                        cur_valid <= 1'b1;
                    end else begin
                        nxt_addr <= addr_wdata & ADDR_MASK;
                        armed    <= 1'b1;
                    end
                end
            end
        end
    end

    assign last = cnt_en && (cur_cnt == CNT_W'(BURST_BYTES));
endmodule

// File: rtl/chain_dma.sv
`timescale 1ns/1ps
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int CNT_W        = 24,
    parameter int BURST_WORDS  = 16,
    parameter int DRAIN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_done,
    input  logic              mem_err,
    output logic              irq
);
    localparam int BURST_BYTES = BURST_WORDS * 4;

    logic int_pend, err_pend, tc, int_en, dma_en, cnt_en, nxt_en, dir_wr, rst_bit;
    logic cyc_pend, draining, busy;
    logic step, err_evt, tc_evt, promote, stop;
    logic cur_valid, armed, last, can_chain, run;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic csr_wr, cnt_wr, addr_wr;

    assign csr_wr    = reg_wr && (reg_sel == SEL_CSR);
    assign cnt_wr    = reg_wr && (reg_sel == SEL_CNT);
    assign addr_wr   = reg_wr && (reg_sel == SEL_ADDR);
    assign busy      = cyc_pend | draining;
    assign can_chain = nxt_en & armed;
    assign run       = dma_en & cur_valid & ~rst_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_pend <= 1'b0; err_pend <= 1'b0; tc     <= 1'b0;
            int_en   <= 1'b0; dma_en   <= 1'b0; cnt_en <= 1'b0;
            nxt_en   <= 1'b0; dir_wr   <= 1'b0; rst_bit <= 1'b0;
        end else begin
            if (csr_wr) begin
                int_en <= reg_wdata[B_INTEN];
                cnt_en <= reg_wdata[B_CNTEN];
                nxt_en <= reg_wdata[B_NXTEN];
                dir_wr <= reg_wdata[B_DIR];
                dma_en <= reg_wdata[B_EN] & ~reg_wdata[B_RST] & ~(rst_bit & busy);
                if (reg_wdata[B_RST])  rst_bit <= 1'b1;
                else if (!busy)        rst_bit <= 1'b0;
                if (reg_wdata[B_INT])  int_pend <= 1'b0;
                if (reg_wdata[B_ERR])  err_pend <= 1'b0;
                if (reg_wdata[B_TC])   tc       <= 1'b0;
            end
            if (tc_evt) begin
                tc <= 1'b1;
                if (int_en) int_pend <= 1'b1;
            end
            if (err_evt) begin
                err_pend <= 1'b1;
                dma_en   <= 1'b0;
            end
            if (stop) dma_en <= 1'b0;
            if (rst_bit) begin
                int_pend <= 1'b0;
                err_pend <= 1'b0;
            end
        end
    end

    cdma_fsm #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .dma_en(dma_en), .rst_bit(rst_bit),
        .dir_wr(dir_wr), .last(last), .can_chain(can_chain),
        .mem_gnt(mem_gnt), .mem_done(mem_done), .mem_err(mem_err),
        .mem_req(mem_req), .cyc_pend(cyc_pend), .draining(draining),
        .step(step), .err_evt(err_evt), .tc_evt(tc_evt),
        .promote(promote), .stop(stop)
    );

    cdma_desc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)) u_desc (
        .clk(clk), .rst_n(rst_n), .flush(rst_bit),
        .cnt_wr(cnt_wr), .cnt_wdata(reg_wdata[CNT_W-1:0]),
        .addr_wr(addr_wr), .addr_wdata(reg_wdata[ADDR_W-1:0]),
        .cnt_en(cnt_en), .step(step), .promote(promote), .stop(stop),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .cur_valid(cur_valid),
        .armed(armed), .last(last)
    );

    assign mem_addr = cur_addr;
    assign mem_we   = dir_wr;
    assign irq      = (int_pend & int_en) | err_pend;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CSR: begin
                reg_rdata[B_INT]   = int_pend;
                reg_rdata[B_ERR]   = err_pend;
                reg_rdata[B_TC]    = tc;
                reg_rdata[B_INTEN] = int_en;
                reg_rdata[B_EN]    = dma_en;
                reg_rdata[B_CNTEN] = cnt_en;
                reg_rdata[B_NXTEN] = nxt_en;
                reg_rdata[B_DIR]   = dir_wr;
                reg_rdata[B_RST]   = rst_bit;
                reg_rdata[B_CYC]   = cyc_pend;
                reg_rdata[B_DRN]   = draining;
                reg_rdata[B_ARM]   = armed;
            end
            SEL_ADDR: reg_rdata = 32'(cur_addr);
            SEL_CNT:  reg_rdata = 32'(cur_cnt);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/chain_dma_chk.sv
`timescale 1ns/1ps
module chain_dma_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_req,
    input logic mem_gnt,
    input logic mem_done,
    input logic mem_err,
    input logic irq,
    input logic dma_en,
    input logic rst_bit,
    input logic cyc_pend,
    input logic draining,
    input logic last,
    input logic can_chain,
    input logic tc
);
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt && dma_en && !rst_bit |=> mem_req);

    a_r7_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_pend && mem_done && mem_err && !rst_bit |=> irq && !dma_en);

    a_r5_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_pend && mem_done && !mem_err && !rst_bit && last |=> tc);

    a_r6_gapless: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_pend && mem_done && !mem_err && !rst_bit && last && can_chain && dma_en |=> mem_req);

    a_r8_reset_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_bit && (cyc_pend || draining) |=> rst_bit);

    a_r8_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_bit |=> !mem_req);

    a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, cyc_pend, draining}));
endmodule

bind chain_dma chain_dma_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_done(mem_done), .mem_err(mem_err), .irq(irq), .dma_en(dma_en),
    .rst_bit(rst_bit), .cyc_pend(cyc_pend), .draining(draining),
    .last(last), .can_chain(can_chain), .tc(tc)
);

// File: tb/sim_chain_dma.sv
`timescale 1ns/1ps
module sim_chain_dma;
    import chain_dma_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  reg_sel;
    logic        reg_wr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_req, mem_gnt, mem_we, mem_done, mem_err, irq;
    logic [31:0] mem_addr;

    always #2.5 clk = ~clk;

    chain_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_done(mem_done), .mem_err(mem_err), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // memory responder and burst log
    int lat = 2;
    int err_at = -1;
    int nb = 0;
    int busy = 0;
    int cyc = 0;
    logic [31:0] la [64];
    logic        lw [64];
    int          lt [64];

    initial begin
        mem_gnt = 0; mem_done = 0; mem_err = 0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_gnt = 0; mem_done = 0; mem_err = 0;
            if (busy > 0) begin
                busy--;
                if (busy == 0) begin
                    mem_done = 1;
                    mem_err = ((nb - 1) == err_at);
                end
            end else if (mem_req) begin
                mem_gnt = 1;
                if (nb < 64) begin la[nb] = mem_addr; lw[nb] = mem_we; lt[nb] = cyc; end
                nb++;
                busy = lat;
            end
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic clean();
        wr(SEL_CSR, (32'd1 << B_RST) | 32'd7);
        wr(SEL_CSR, 32'd0);
        nb = 0; err_at = -1;
    endtask

    task automatic wait_stop();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(SEL_CSR, v);
            if (!v[B_EN] && !v[B_CYC] && !v[B_DRN]) break;
        end
    endtask

    localparam logic [31:0] EN  = 32'd1 << B_EN;
    localparam logic [31:0] CE  = 32'd1 << B_CNTEN;
    localparam logic [31:0] IE  = 32'd1 << B_INTEN;
    localparam logic [31:0] NE  = 32'd1 << B_NXTEN;
    localparam logic [31:0] DR  = 32'd1 << B_DIR;
    localparam logic [31:0] RS  = 32'd1 << B_RST;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, base, a2;
        int n0;
        rst_n = 0; reg_sel = 0; reg_wr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(SEL_CSR, v);
        chk("R1 csr", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 req", {31'd0, mem_req}, 0);

        // R4 R5 R6 R10 R12 single descriptor sweep
        for (int l = 1; l <= 2; l++)
            for (int d = 0; d <= 1; d++)
                for (int n = 1; n <= 4; n++) begin
                    lat = l;
                    clean();
                    base = 32'h0001_0000 + n * 32'h400 + d * 32'h8000 + l * 32'h4_0000;
                    wr(SEL_CNT, n * 64);
                    wr(SEL_ADDR, base);
                    wr(SEL_CSR, EN | CE | IE | (d ? DR : 0));
                    wait_stop();
                    chk("R4 burst count", nb, n);
                    for (int i = 0; i < n; i++) begin
                        chk("R4 address", la[i], base + 64 * i);
                        chk("R4 direction", {31'd0, lw[i]}, d);
                        if (i > 0) chk("R4 spacing", lt[i] - lt[i-1], l + 1);
                    end
                    rd(SEL_CSR, v);
                    chk("R5 tc", v[B_TC], 1);
                    chk("R5 int_pend", v[B_INT], 1);
                    chk("R6 stop clears enable", v[B_EN], 0);
                    chk("R12 irq raised", {31'd0, irq}, 1);
                    rd(SEL_CNT, a2);
                    chk("R5 count zero", a2, 0);
                    wr(SEL_CSR, v);
                    rd(SEL_CSR, v);
                    chk("R10 writeback clears", v & 32'h7, 0);
                    chk("R12 irq cleared", {31'd0, irq}, 0);
                end

        // R3 R6 chaining sweep
        lat = 2;
        for (int n1 = 1; n1 <= 3; n1++)
            for (int n2 = 1; n2 <= 3; n2++) begin
                clean();
                base = 32'h0020_0000 + n1 * 32'h1000;
                a2   = 32'h0030_0000 + n2 * 32'h1000;
                wr(SEL_CNT, n1 * 64); wr(SEL_ADDR, base);
                wr(SEL_CNT, n2 * 64); wr(SEL_ADDR, a2);
                rd(SEL_CSR, v);
                chk("R3 armed", v[B_ARM], 1);
                wr(SEL_CSR, EN | CE | IE | NE);
                wait_stop();
                chk("R6 total bursts", nb, n1 + n2);
                chk("R6 promoted address", la[n1], a2);
                chk("R6 no gap", lt[n1] - lt[n1-1], lat + 1);
                rd(SEL_CSR, v);
                chk("R6 armed cleared", v[B_ARM], 0);
                chk("R5 tc after chain", v[B_TC], 1);
            end

        // R3 low bits dropped
        clean();
        wr(SEL_CNT, 2 * 64 + 13);
        wr(SEL_ADDR, 32'h0000_2005);
        rd(SEL_CNT, v);  chk("R3 count masked", v, 128);
        rd(SEL_ADDR, v); chk("R3 address masked", v, 32'h2000);
        wr(SEL_CSR, EN | CE);
        wait_stop();
        chk("R3 masked bursts", nb, 2);

        // R3 zero count ignored
        clean();
        wr(SEL_CNT, 0);
        wr(SEL_ADDR, 32'h3000);
        wr(SEL_CSR, EN | CE);
        repeat (20) @(negedge clk);
        chk("R3 zero count no burst", nb, 0);
        rd(SEL_CSR, v);
        chk("R3 zero count not armed", v[B_ARM], 0);

        // R5 R12 interrupt enable off
        clean();
        wr(SEL_CNT, 64); wr(SEL_ADDR, 32'h4000);
        wr(SEL_CSR, EN | CE);
        wait_stop();
        rd(SEL_CSR, v);
        chk("R5 tc without int_en", v[B_TC], 1);
        chk("R5 no int_pend", v[B_INT], 0);
        chk("R12 irq quiet", {31'd0, irq}, 0);

        // R11 count disabled, R9 halt
        clean();
        base = 32'h5000;
        wr(SEL_CNT, 64); wr(SEL_ADDR, base);
        wr(SEL_CSR, EN);
        repeat (30) @(negedge clk);
        rd(SEL_CNT, v);
        chk("R11 count held", v, 64);
        rd(SEL_CSR, v);
        chk("R11 no tc", v[B_TC], 0);
        wr(SEL_CSR, 0);
        wait_stop();
        n0 = nb;
        chk("R11 kept running", {31'd0, n0 > 2}, 1);
        for (int i = 0; i < 3; i++) chk("R4 address step", la[i], base + 64 * i);
        repeat (20) @(negedge clk);
        chk("R9 halted", nb, n0);

        // R7 error, R10, R8 recovery
        clean();
        lat = 2; err_at = 1;
        wr(SEL_CNT, 4 * 64); wr(SEL_ADDR, 32'h6000);
        wr(SEL_CSR, EN | CE | IE);
        wait_stop();
        chk("R7 bursts until error", nb, 2);
        rd(SEL_CSR, v);
        chk("R7 err_pend", v[B_ERR], 1);
        chk("R7 enable cleared", v[B_EN], 0);
        repeat (10) @(negedge clk);
        chk("R12 irq held", {31'd0, irq}, 1);
        wr(SEL_CSR, 0);
        rd(SEL_CSR, v);
        chk("R10 zero write keeps err", v[B_ERR], 1);
        wr(SEL_CSR, RS);
        rd(SEL_CSR, v);
        chk("R8 reset clears err", v[B_ERR], 0);
        chk("R8 reset bit", v[B_RST], 1);
        chk("R8 irq dropped", {31'd0, irq}, 0);

        // R8 reset during capture burst, drain
        clean();
        lat = 12;
        wr(SEL_CNT, 4 * 64); wr(SEL_ADDR, 32'h7000);
        wr(SEL_CSR, EN | CE | DR);
        for (int i = 0; i < 100 && nb < 1; i++) @(negedge clk);
        wr(SEL_CSR, RS | DR);
        rd(SEL_CSR, v);
        chk("R8 cycle pending", v[B_CYC], 1);
        wr(SEL_CSR, DR);
        rd(SEL_CSR, v);
        chk("R8 reset stuck while busy", v[B_RST], 1);
        chk("R8 request withdrawn", {31'd0, mem_req}, 0);
        for (int i = 0; i < 50; i++) begin
            rd(SEL_CSR, v);
            if (v[B_DRN]) break;
        end
        n0 = 0;
        while (v[B_DRN] && n0 < 50) begin
            n0++;
            rd(SEL_CSR, v);
        end
        chk("R8 drain length", n0, 4);
        wr(SEL_CSR, 0);
        rd(SEL_CSR, v);
        chk("R8 reset released", v[B_RST], 0);
        chk("R8 no burst after reset", nb, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule